// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer Bank

The block holds five down-counting timer channels. Each has a software-visible count buffer and compare buffer. The live counter and live compare value are loaded from those buffers only in two cases: a manual-update request, or an underflow while auto-reload is on. So software can stage a new period and duty at any time, and the change takes effect cleanly at the next period boundary.

A single control word carries four bits for each channel: start, manual update, output invert and auto-reload. Channel 0 sits in the lowest nibble. The nibble after it is left empty, and each later channel sits one nibble further up. Channel 4 has no output pin, so its auto-reload bit takes the slot the invert bit has in the other nibbles. Each channel counts only on cycles where its tick enable, supplied by an external divider, is high. Channels 0 to 3 drive a PWM pin. Every channel gives a one-cycle expiry pulse when its counter underflows.

To set up a channel, software writes both buffers, pulses manual update, and then sets start together with auto-reload. A compare value of all ones keeps the pin at its active level for the whole period.

Top module: `pwm_timer_bank`

## Requirements
- R1: Channel n (0..4) has its count buffer at byte offset 0x0C+12n and its compare buffer at 0x10+12n. The control word is at 0x08. A write stores the low CNT_W bits of the data. A read returns the buffered value zero-extended, never the live count. Every other offset reads as 0.
- R2: Channel 0 owns control bits 3:0, and channel n≥1 owns nibble n+1. Within a nibble, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload. Bits 7:4 and 31:23 are not stored and read as 0, so writing all ones reads back 0x007FFF0F.
- R3: Channel 4 uses bit 20 for start, bit 21 for manual update and bit 22 for auto-reload. It has no invert bit and no pin. Bit 23 has no effect on it.
- R4: While a channel's manual-update bit is 1, its live counter and compare are loaded from the buffers on every cycle. The channel does not count and gives no expiry.
- R5: With start 1 and the tick enable 1, the counter steps down once per cycle. With count buffer N, a period lasts N+1 ticks. The expiry output is high for exactly the one cycle after the tick that underflows from 0, and that is the same cycle in which the counter shows N again.
- R6: With compare C and invert 0, the pin is high for N−C ticks of each period when C<N. It is high for no ticks when N≤C<all-ones. It is high for all N+1 ticks when C is all ones.
- R7: The invert bit complements the pin level, both while the channel runs and while it is idle.
- R8: While start is 0, or after a one-shot channel has stopped, the pin equals the invert bit.
- R9: With auto-reload 1, the counter reloads from the buffers at underflow. With auto-reload 0, the channel gives one final expiry and then stops with no further expiries. Only a manual update re-arms it.
- R10: A buffer write during a running period does not change that period. The new value takes effect from the next reload.
- R11: A cycle whose tick enable is 0 does not move the counter. With ticks on every other cycle, the expiry interval is 2(N+1) cycles.
- R12: After reset, all buffers and the control word read 0, all pins are low and no expiry is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tick_en | input | 5 | Per-channel tick enable from the divider |
| pwm_out | output | 4 | PWM pins of channels 0 to 3 |
| expire | output | 5 | One-cycle underflow pulse per channel |

## Verification
The assertions take three things for granted. Tick enables may change freely. A manual-update bit in the stored control word always suppresses the next expiry. The stored control word changes only through register writes. The stimulus keeps the count buffer at 1 or more whenever a channel runs, so each period has at least two ticks. It holds manual update for a full write cycle before it sets start, and it clears the control word between sweep points so that every measurement begins from a freshly loaded counter. Duty is measured over a window of exactly N+1 cycles that starts at an observed expiry, so the result does not depend on the phase at which start was applied.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int NUM_CH  = 5;
    localparam int NUM_PIN = 4;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h08;

    typedef struct packed {
        logic start;
        logic manual;
        logic invert;
        logic reload;
    } ch_ctrl_t;

    function automatic logic [ADDR_W-1:0] cnt_addr(input int ch);
        return ADDR_W'(12 + 12 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_addr(input int ch);
        return ADDR_W'(16 + 12 * ch);
    endfunction

    // nibble 1 is skipped: channel 0 at nibble 0, channel n at nibble n+1
    function automatic int nib_base(input int ch);
        return (ch == 0) ? 0 : 4 * (ch + 1);
    endfunction

    function automatic int start_pos(input int ch);
        return nib_base(ch);
    endfunction

    function automatic int manual_pos(input int ch);
        return nib_base(ch) + 1;
    endfunction

    function automatic int invert_pos(input int ch);
        return nib_base(ch) + 2;
    endfunction

    // the pinless last channel keeps auto-reload in the invert slot
    function automatic int reload_pos(input int ch);
        return (ch == NUM_CH - 1) ? nib_base(ch) + 2 : nib_base(ch) + 3;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            m[start_pos(ch)]  = 1'b1;
            m[manual_pos(ch)] = 1'b1;
            m[reload_pos(ch)] = 1'b1;
            if (ch < NUM_PIN) m[invert_pos(ch)] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask();

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [DATA_W-1:0]                 rdata,
    output logic [DATA_W-1:0]                 ctrl_word,
    output ch_ctrl_t [NUM_CH-1:0]             cfg,
    output logic [NUM_CH-1:0][CNT_W-1:0]      cnt_buf,
    output logic [NUM_CH-1:0][CNT_W-1:0]      cmp_buf
);

    typedef struct packed {
        logic [DATA_W-1:0]              ctrl;
        logic [NUM_CH-1:0][CNT_W-1:0]   cnt;
        logic [NUM_CH-1:0][CNT_W-1:0]   cmp;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            if (addr == CTRL_ADDR) regs_d.ctrl = wdata & CTRL_MASK;
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (addr == cnt_addr(ch)) regs_d.cnt[ch] = wdata[CNT_W-1:0];
                if (addr == cmp_addr(ch)) regs_d.cmp[ch] = wdata[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR) rdata = regs_q.ctrl;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (addr == cnt_addr(ch)) rdata = DATA_W'(regs_q.cnt[ch]);
            if (addr == cmp_addr(ch)) rdata = DATA_W'(regs_q.cmp[ch]);
        end
    end

    assign ctrl_word = regs_q.ctrl;
    assign cnt_buf   = regs_q.cnt;
    assign cmp_buf   = regs_q.cmp;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_decode
        localparam int SP = start_pos(g);
        localparam int MP = manual_pos(g);
        localparam int RP = reload_pos(g);
        assign cfg[g].start  = regs_q.ctrl[SP];
        assign cfg[g].manual = regs_q.ctrl[MP];
        assign cfg[g].reload = regs_q.ctrl[RP];
        if (g < NUM_PIN) begin : g_inv
            localparam int IP = invert_pos(g);
            assign cfg[g].invert = regs_q.ctrl[IP];
        end else begin : g_noinv
            assign cfg[g].invert = 1'b0;
        end
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  ch_ctrl_t         cfg,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic             level,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             done;
        logic             expire;
    } chan_t;

    chan_t chan_d, chan_q;
    logic  running;
    logic  active;

    always_comb begin
        chan_d        = chan_q;
        chan_d.expire = 1'b0;
        if (cfg.manual) begin
            chan_d.cnt  = cnt_buf;
            chan_d.cmp  = cmp_buf;
            chan_d.done = 1'b0;
        end else if (cfg.start && !chan_q.done && tick) begin
            if (chan_q.cnt == '0) begin
                chan_d.expire = 1'b1;
                if (cfg.reload) begin
                    chan_d.cnt = cnt_buf;
                    chan_d.cmp = cmp_buf;
                end else begin
                    chan_d.done = 1'b1;
                end
            end else begin
                chan_d.cnt = chan_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign running = cfg.start && !chan_q.done;
    assign active  = running && ((chan_q.cmp == ALL_ONES) || (chan_q.cnt > chan_q.cmp));
    assign level   = active ^ cfg.invert;
    assign expire  = chan_q.expire;

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [4:0]  tick_en,
    output logic [3:0]  pwm_out,
    output logic [4:0]  expire
);

    logic [DATA_W-1:0]            ctrl_word;
    ch_ctrl_t [NUM_CH-1:0]        cfg;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf;

    pwm_regs #(.CNT_W(CNT_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .ctrl_word (ctrl_word),
        .cfg       (cfg),
        .cnt_buf   (cnt_buf),
        .cmp_buf   (cmp_buf)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        if (g < NUM_PIN) begin : g_pin
            pwm_chan #(.CNT_W(CNT_W)) i_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick_en[g]),
                .cfg     (cfg[g]),
                .cnt_buf (cnt_buf[g]),
                .cmp_buf (cmp_buf[g]),
                .level   (pwm_out[g]),
                .expire  (expire[g])
            );
        end else begin : g_nopin
            logic spare_lvl_unused;
            pwm_chan #(.CNT_W(CNT_W)) i_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick_en[g]),
                .cfg     (cfg[g]),
                .cnt_buf (cnt_buf[g]),
                .cmp_buf (cmp_buf[g]),
                .level   (spare_lvl_unused),
                .expire  (expire[g])
            );
        end
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [DATA_W-1:0]  ctrl_word,
    input logic [NUM_CH-1:0]  tick_en,
    input logic [NUM_CH-1:0]  expire,
    input logic [NUM_PIN-1:0] pwm_out
);

    AST_CTRL_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word & ~CTRL_MASK) == '0); // R2

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int SP = start_pos(g);
        localparam int MP = manual_pos(g);

        AST_MANUAL_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_word[MP] |=> !expire[g]); // R4

        AST_STOPPED_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_word[SP] |=> !expire[g]); // R5

        AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            !tick_en[g] |=> !expire[g]); // R11
    end

    for (genvar g = 0; g < NUM_PIN; g++) begin : g_pin
        localparam int SP = start_pos(g);
        localparam int IP = invert_pos(g);

        AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_word[SP] |-> pwm_out[g] == ctrl_word[IP]); // R8
    end

endmodule

bind pwm_timer_bank pwm_bank_chk i_pwm_bank_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl_word),
    .tick_en   (tick_en),
    .expire    (expire),
    .pwm_out   (pwm_out)
);

// File: tb/test_pwm_timer_bank.sv
module test_pwm_timer_bank;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] ONES = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  tick_base = '1;
    logic        half_mode = 1'b0;
    logic        tick_alt = 1'b0;
    logic [4:0]  tick_en;
    logic [3:0]  pwm_out;
    logic [4:0]  expire;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(negedge clk) tick_alt <= ~tick_alt;
    assign tick_en = half_mode ? (tick_base & {5{tick_alt}}) : tick_base;

    pwm_timer_bank i_pwm_timer_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tick_en   (tick_en),
        .pwm_out   (pwm_out),
        .expire    (expire)
    );

    function automatic logic [7:0] a_cnt(input int ch);
        return 8'(8'h0C + 12 * ch);
    endfunction

    function automatic logic [7:0] a_cmp(input int ch);
        return 8'(8'h10 + 12 * ch);
    endfunction

    function automatic logic [31:0] ctl(input int ch, input bit s, input bit m,
                                        input bit inv, input bit r);
        int b;
        logic [31:0] w;
        b = (ch == 0) ? 0 : 4 * (ch + 1);
        w = '0;
        w[b]     = s;
        w[b + 1] = m;
        if (ch == 4) w[b + 2] = r;
        else begin
            w[b + 2] = inv;
            w[b + 3] = r;
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr_now(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_exp(input int ch, input int maxc, output int n);
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (expire[ch]) return;
            if (n >= maxc) begin
                n = -1;
                return;
            end
        end
    endtask

    task automatic measure(input int ch, input int n, input logic [15:0] c, input bit inv);
        int w;
        int highs;
        int exp_hi;
        bit stray;
        wr(a_cnt(ch), 32'(n));
        wr(a_cmp(ch), 32'(c));
        wr(8'h08, ctl(ch, 0, 1, inv, 0));
        chk(pwm_out[ch] == inv, "R7 R8 idle level", 32'(pwm_out[ch]), 32'(inv));
        wr(8'h08, ctl(ch, 1, 0, inv, 1));
        wait_exp(ch, 3 * n + 10, w);
        chk(w != -1, "R5 first expiry", 32'(w), 32'(1));
        highs = 0;
        stray = 1'b0;
        highs += int'(pwm_out[ch]);
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            highs += int'(pwm_out[ch]);
            if (expire[ch]) stray = 1'b1;
        end
        @(negedge clk);
        chk(!stray && expire[ch], "R5 period N+1", 32'(stray), 32'(0));
        if (c == ONES)  exp_hi = n + 1;
        else if (c < n) exp_hi = n - int'(c);
        else            exp_hi = 0;
        if (inv) exp_hi = n + 1 - exp_hi;
        chk(highs == exp_hi, inv ? "R6 R7 duty inverted" : "R6 duty", 32'(highs), 32'(exp_hi));
        wr(8'h08, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n1;
        int n2;
        bit stay;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk(pwm_out == 4'h0, "R12 pins low", 32'(pwm_out), 0);
        chk(expire == 5'h0, "R12 no expiry", 32'(expire), 0);
        rd(8'h08, d);
        chk(d == 0, "R12 ctrl zero", d, 0);
        rd(a_cmp(4), d);
        chk(d == 0, "R12 buffer zero", d, 0);

        // R1 register map and readback
        for (int ch = 0; ch < 5; ch++) begin
            wr(a_cnt(ch), 32'hABC00000 | 32'(16'h1100 + ch));
            wr(a_cmp(ch), 32'(16'h2200 + ch));
        end
        for (int ch = 0; ch < 5; ch++) begin
            rd(a_cnt(ch), d);
            chk(d == 32'(16'h1100 + ch), "R1 count buffer readback", d, 32'(16'h1100 + ch));
            rd(a_cmp(ch), d);
            chk(d == 32'(16'h2200 + ch), "R1 compare buffer readback", d, 32'(16'h2200 + ch));
        end
        rd(8'h04, d);
        chk(d == 0, "R1 unmapped reads zero", d, 0);
        rd(8'h44, d);
        chk(d == 0, "R1 unmapped reads zero", d, 0);

        // R2 control word storage mask
        wr(8'h08, 32'hFFFFFFFF);
        rd(8'h08, d);
        chk(d == 32'h007FFF0F, "R2 control mask", d, 32'h007FFF0F);
        wr(8'h08, 32'h0);

        // R6 R7 R5 sweep over channels, periods and compare values
        for (int ch = 0; ch < 4; ch++) begin
            for (int n = 1; n <= 5; n++) begin
                for (int c = 0; c <= n + 2; c++) begin
                    logic [15:0] cv;
                    cv = (c == n + 2) ? ONES : 16'(c);
                    measure(ch, n, cv, 1'((ch + n + c) % 2));
                end
            end
        end

        // R3 channel 4 auto-reload at bit 22
        wr(a_cnt(4), 32'd3);
        wr(8'h08, 32'h00200000);
        wr(8'h08, 32'h00500000);
        wait_exp(4, 20, n1);
        wait_exp(4, 20, n2);
        chk(n2 == 4, "R3 ch4 reload interval", 32'(n2), 32'd4);
        // R3 bit 23 is not channel 4's reload: runs one-shot
        wr(8'h08, 32'h00200000);
        wr(8'h08, 32'h00900000);
        rd(8'h08, d);
        chk(d == 32'h00100000, "R3 bit 23 dropped", d, 32'h00100000);
        wait_exp(4, 20, n1);
        chk(n1 != -1, "R3 ch4 one-shot expiry", 32'(n1), 32'd1);
        wait_exp(4, 20, n2);
        chk(n2 == -1, "R3 R9 ch4 stops without bit 22", 32'(n2), 32'hFFFFFFFF);
        wr(8'h08, 32'h0);

        // R9 one-shot on a pin channel
        wr(a_cnt(0), 32'd3);
        wr(a_cmp(0), 32'd1);
        wr(8'h08, ctl(0, 0, 1, 0, 0));
        wr(8'h08, ctl(0, 1, 0, 0, 0));
        wait_exp(0, 20, n1);
        chk(n1 != -1, "R9 final expiry", 32'(n1), 32'd1);
        stay = 1'b1;
        for (int j = 0; j < 15; j++) begin
            @(negedge clk);
            if (expire[0] || pwm_out[0]) stay = 1'b0;
        end
        chk(stay, "R9 R8 stopped quiet and idle", 32'(stay), 32'd1);
        wr(8'h08, ctl(0, 1, 1, 0, 0));
        wr(8'h08, ctl(0, 1, 0, 0, 0));
        wait_exp(0, 20, n1);
        chk(n1 != -1, "R9 manual re-arms", 32'(n1), 32'd1);
        wr(8'h08, 32'h0);

        // R10 buffered period change
        wr(a_cnt(1), 32'd3);
        wr(a_cmp(1), 32'd0);
        wr(8'h08, ctl(1, 0, 1, 0, 0));
        wr(8'h08, ctl(1, 1, 0, 0, 1));
        wait_exp(1, 20, n1);
        wr_now(a_cnt(1), 32'd6);
        wait_exp(1, 20, n1);
        chk(n1 == 3, "R10 current period kept", 32'(n1), 32'd3);
        wait_exp(1, 20, n2);
        chk(n2 == 7, "R10 new period after reload", 32'(n2), 32'd7);
        rd(a_cnt(1), d);
        chk(d == 32'd6, "R1 read gives buffer not live count", d, 32'd6);
        wr(8'h08, 32'h0);

        // R11 tick gating
        wr(a_cnt(2), 32'd2);
        wr(8'h08, ctl(2, 0, 1, 0, 0));
        tick_base[2] = 1'b0;
        wr(8'h08, ctl(2, 1, 0, 0, 1));
        wait_exp(2, 30, n1);
        chk(n1 == -1, "R11 no tick no expiry", 32'(n1), 32'hFFFFFFFF);
        tick_base[2] = 1'b1;
        half_mode = 1'b1;
        wait_exp(2, 30, n1);
        wait_exp(2, 30, n2);
        chk(n2 == 6, "R11 half-rate interval", 32'(n2), 32'd6);
        half_mode = 1'b0;
        wr(8'h08, 32'h0);

        // R4 manual update held suppresses counting
        wr(a_cnt(3), 32'd2);
        wr(8'h08, ctl(3, 1, 1, 0, 1));
        wait_exp(3, 20, n1);
        chk(n1 == -1, "R4 manual holds counter", 32'(n1), 32'hFFFFFFFF);
        wr(8'h08, ctl(3, 1, 0, 0, 1));
        wait_exp(3, 20, n1);
        wait_exp(3, 20, n2);
        chk(n2 == 3, "R4 resumes after release", 32'(n2), 32'd3);
        wr(8'h08, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule